// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block keeps a small record of the stores issued so far in the current dispatch group. It checks every later load in the same group against that record. When the load could read bytes that one of those stores writes, it asks the scheduler to insert a no-op. Addresses are never computed. Each access gives two address operands, and each operand is either a register tag or a constant offset, marked by a flag. Each access also gives an encoded byte size. The check works on these operands as symbols.

A load hits a recorded store in three cases:
- its two operands equal the store's two operands in the same order;
- its two operands equal the store's two operands in swapped order;
- both accesses share the second operand, both first operands are constants, and the two byte ranges `[offset, offset+size)` overlap.

All recorded entries are compared at once. The no-op request is registered. A group-end pulse empties the record. A store that arrives when the record is full is dropped, and it sets a sticky overflow flag.

Top module: `stld_overlap_det`

## Requirements
- R1: After synchronous reset, `noop_req_o` and `ovf_o` are 0 and no store is recorded, so a following load gives no request.
- R2: A load whose first and second operands (constant flag and 16-bit value both) equal those of a recorded store, in the same order, raises `noop_req_o`.
- R3: A load whose operands equal a recorded store's operands in swapped order (load first = store second, load second = store first) raises `noop_req_o`.
- R4: Size code c (0 to 4) means 2^c bytes. If both accesses have equal second operands and constant first operands, they hit when the lower offset plus its own size is greater than the higher offset. For equal offsets, the store counts as the lower one.
- R5: No hit results when the second operands differ and there is no swapped match, or when either first operand is not constant and the first operands differ, or when the constant ranges are merely adjacent.
- R6: `noop_req_o` is raised only for a cycle with `ld_valid_i` high and at least one recorded store. A store cycle alone never raises it.
- R7: A store presented in the same cycle as a load is not compared with that load. The store becomes visible to loads from the next cycle on.
- R8: `grp_end_i` empties the record at the clock edge. A load in that same cycle is still checked against the old record. A store in that same cycle is discarded.
- R9: The record holds 4 stores. A fifth store in a group is dropped and sets `ovf_o`. `ovf_o` stays set until reset, and the entries already held still match.
- R10: Offsets are unsigned 16-bit values. The end of a range is computed at 17 bits without wrapping, so a store at 0xFFF8 of 16 bytes overlaps a load at 0xFFFF.
- R11: `noop_req_o` is registered. It is high in the cycle after the load cycle and for one cycle per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_end_i | input | 1 | Dispatch group ends; record is emptied |
| st_valid_i | input | 1 | A store is issued this cycle |
| st_a_const_i | input | 1 | Store first operand is a constant |
| st_a_val_i | input | 16 | Store first operand tag or offset |
| st_b_const_i | input | 1 | Store second operand is a constant |
| st_b_val_i | input | 16 | Store second operand tag or offset |
| st_size_i | input | 3 | Store size code, 2^code bytes |
| ld_valid_i | input | 1 | A load is issued this cycle |
| ld_a_const_i | input | 1 | Load first operand is a constant |
| ld_a_val_i | input | 16 | Load first operand tag or offset |
| ld_b_const_i | input | 1 | Load second operand is a constant |
| ld_b_val_i | input | 16 | Load second operand tag or offset |
| ld_size_i | input | 3 | Load size code, 2^code bytes |
| noop_req_o | output | 1 | Registered request to insert a no-op |
| ovf_o | output | 1 | Sticky flag: a store was dropped on a full record |

## Verification
The assertions take for granted that any store or load marked valid carries a size code from 0 to 4. Codes 5 to 7 have no meaning for this block. The bench sweeps only codes 0 through 4 for both accesses. It keeps the constant offsets of the sweep small, and it reaches the 16-bit edge only through chosen cases. This keeps the expected overlap arithmetic inside the defined range.

// File: rtl/stld_pkg.sv
package stld_pkg;
  parameter int VAL_W = 16;
  parameter int SZ_W  = 3;
  localparam int MAX_SZ_CODE = 4;

  typedef struct packed {
    logic             is_const;
    logic [VAL_W-1:0] val;
  } operand_t;

  function automatic logic [VAL_W:0] size_bytes(input logic [SZ_W-1:0] code);
    return {{VAL_W{1'b0}}, 1'b1} << code;
  endfunction
endpackage

// File: rtl/stld_entry_cmp.sv
module stld_entry_cmp
  import stld_pkg::*;
(
  input  logic            ent_valid,
  input  operand_t        ent_a,
  input  operand_t        ent_b,
  input  logic [SZ_W-1:0] ent_size,
  input  operand_t        ld_a,
  input  operand_t        ld_b,
  input  logic [SZ_W-1:0] ld_size,
  output logic            hit
);
  logic             exact, swapped, shared_base, ovl;
  logic [VAL_W:0]   st_end, ld_end;

  always_comb begin
    exact       = (ld_a == ent_a) && (ld_b == ent_b);
    swapped     = (ld_a == ent_b) && (ld_b == ent_a);
    shared_base = (ld_b == ent_b) && ent_a.is_const && ld_a.is_const;
    st_end      = {1'b0, ent_a.val} + size_bytes(ent_size);
    ld_end      = {1'b0, ld_a.val} + size_bytes(ld_size);
    if (ent_a.val <= ld_a.val)
      ovl = st_end > {1'b0, ld_a.val};
    else
      ovl = ld_end > {1'b0, ent_a.val};
    hit = ent_valid && (exact || swapped || (shared_base && ovl));
  end
endmodule

// File: rtl/stld_store_table.sv
module stld_store_table
  import stld_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  operand_t         wr_a,
  input  operand_t         wr_b,
  input  logic [SZ_W-1:0]  wr_size,
  output logic             ent_valid [DEPTH],
  output operand_t         ent_a     [DEPTH],
  output operand_t         ent_b     [DEPTH],
  output logic [SZ_W-1:0]  ent_size  [DEPTH],
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  operand_t        mem_a    [DEPTH];
  operand_t        mem_b    [DEPTH];
  logic [SZ_W-1:0] mem_size [DEPTH];
  logic            accept;

  assign accept = wr_en && !clr && (cnt < FULL);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (accept)
      cnt <= cnt + 1'b1;
  end

  // write port only, no reset on storage
  always_ff @(posedge clk) begin
    if (accept) begin
      mem_a[cnt[IDX_W-1:0]]    <= wr_a;
      mem_b[cnt[IDX_W-1:0]]    <= wr_b;
      mem_size[cnt[IDX_W-1:0]] <= wr_size;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_rd
    assign ent_valid[i] = (CNT_W'(i) < cnt);
    assign ent_a[i]     = mem_a[i];
    assign ent_b[i]     = mem_b[i];
    assign ent_size[i]  = mem_size[i];
  end

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  a_r9_append_one: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr && cnt < FULL) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == FULL) |=> (cnt == FULL));
endmodule

// File: rtl/stld_overlap_det.sv
module stld_overlap_det
  import stld_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_end_i,
  input  logic             st_valid_i,
  input  logic             st_a_const_i,
  input  logic [VAL_W-1:0] st_a_val_i,
  input  logic             st_b_const_i,
  input  logic [VAL_W-1:0] st_b_val_i,
  input  logic [SZ_W-1:0]  st_size_i,
  input  logic             ld_valid_i,
  input  logic             ld_a_const_i,
  input  logic [VAL_W-1:0] ld_a_val_i,
  input  logic             ld_b_const_i,
  input  logic [VAL_W-1:0] ld_b_val_i,
  input  logic [SZ_W-1:0]  ld_size_i,
  output logic             noop_req_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  operand_t         st_a, st_b, ld_a, ld_b;
  logic             ent_valid [DEPTH];
  operand_t         ent_a     [DEPTH];
  operand_t         ent_b     [DEPTH];
  logic [SZ_W-1:0]  ent_size  [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [DEPTH-1:0] hits;
  logic             any_hit;

  assign st_a = '{is_const: st_a_const_i, val: st_a_val_i};
  assign st_b = '{is_const: st_b_const_i, val: st_b_val_i};
  assign ld_a = '{is_const: ld_a_const_i, val: ld_a_val_i};
  assign ld_b = '{is_const: ld_b_const_i, val: ld_b_val_i};

  stld_store_table #(.DEPTH(DEPTH)) table_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (grp_end_i),
    .wr_en    (st_valid_i),
    .wr_a     (st_a),
    .wr_b     (st_b),
    .wr_size  (st_size_i),
    .ent_valid(ent_valid),
    .ent_a    (ent_a),
    .ent_b    (ent_b),
    .ent_size (ent_size),
    .cnt      (cnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    stld_entry_cmp cmp_i (
      .ent_valid(ent_valid[i]),
      .ent_a    (ent_a[i]),
      .ent_b    (ent_b[i]),
      .ent_size (ent_size[i]),
      .ld_a     (ld_a),
      .ld_b     (ld_b),
      .ld_size  (ld_size_i),
      .hit      (hits[i])
    );
  end

  assign any_hit = |hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      noop_req_o <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      noop_req_o <= ld_valid_i && (cnt != '0) && any_hit;
      if (st_valid_i && !grp_end_i && cnt == FULL)
        ovf_o <= 1'b1;
    end
  end

  a_r4_st_size_legal: assert property (@(posedge clk) disable iff (rst)
    st_valid_i |-> (st_size_i <= SZ_W'(MAX_SZ_CODE)));
  a_r4_ld_size_legal: assert property (@(posedge clk) disable iff (rst)
    ld_valid_i |-> (ld_size_i <= SZ_W'(MAX_SZ_CODE)));
  a_r11_noop_after_load: assert property (@(posedge clk) disable iff (rst)
    !ld_valid_i |=> !noop_req_o);
  a_r6_noop_needs_store: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !noop_req_o);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  a_r9_ovf_only_on_full: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> ($past(cnt) == FULL && $past(st_valid_i)));
endmodule

// File: tb/stld_overlap_det_tb.sv
module stld_overlap_det_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        grp_end_i = 1'b0;
  logic        st_valid_i = 1'b0, st_a_const_i = 1'b0, st_b_const_i = 1'b0;
  logic [15:0] st_a_val_i = '0, st_b_val_i = '0;
  logic [2:0]  st_size_i = '0;
  logic        ld_valid_i = 1'b0, ld_a_const_i = 1'b0, ld_b_const_i = 1'b0;
  logic [15:0] ld_a_val_i = '0, ld_b_val_i = '0;
  logic [2:0]  ld_size_i = '0;
  logic        noop_req_o, ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stld_overlap_det dut_i (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  task automatic set_st(input logic ac, input logic [15:0] av, input logic bc,
                        input logic [15:0] bv, input logic [2:0] sz);
    st_valid_i = 1'b1; st_a_const_i = ac; st_a_val_i = av;
    st_b_const_i = bc; st_b_val_i = bv; st_size_i = sz;
  endtask

  task automatic set_ld(input logic ac, input logic [15:0] av, input logic bc,
                        input logic [15:0] bv, input logic [2:0] sz);
    ld_valid_i = 1'b1; ld_a_const_i = ac; ld_a_val_i = av;
    ld_b_const_i = bc; ld_b_val_i = bv; ld_size_i = sz;
  endtask

  task automatic step();
    @(negedge clk);
    st_valid_i = 1'b0; ld_valid_i = 1'b0; grp_end_i = 1'b0;
  endtask

  task automatic store(input logic ac, input logic [15:0] av, input logic bc,
                       input logic [15:0] bv, input logic [2:0] sz);
    set_st(ac, av, bc, bv, sz);
    step();
  endtask

  task automatic load_chk(input string req, input logic ac, input logic [15:0] av,
                          input logic bc, input logic [15:0] bv, input logic [2:0] sz,
                          input logic exp);
    set_ld(ac, av, bc, bv, sz);
    step();
    chk(req, noop_req_o, exp);
  endtask

  task automatic end_grp();
    grp_end_i = 1'b1;
    step();
  endtask

  function automatic logic overlap(input int so, input int ssz, input int lo, input int lsz);
    if (so <= lo) return (so + (1 << ssz)) > lo;
    return (lo + (1 << lsz)) > so;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 noop", noop_req_o, 1'b0);
    chk("R1 ovf", ovf_o, 1'b0);
    load_chk("R1 empty table", 1'b0, 16'd3, 1'b0, 16'd5, 3'd2, 1'b0);
    // R6 load with empty table never hits
    load_chk("R6 empty", 1'b0, 16'd0, 1'b0, 16'd0, 3'd0, 1'b0);

    // R2 exact order, R3 swapped
    store(1'b0, 16'd3, 1'b0, 16'd5, 3'd2);
    chk("R6 store alone", noop_req_o, 1'b0);
    load_chk("R2 exact", 1'b0, 16'd3, 1'b0, 16'd5, 3'd2, 1'b1);
    // R11 single-cycle pulse
    step();
    chk("R11 one cycle", noop_req_o, 1'b0);
    load_chk("R3 swapped", 1'b0, 16'd5, 1'b0, 16'd3, 3'd0, 1'b1);
    load_chk("R5 other tags", 1'b0, 16'd3, 1'b0, 16'd6, 3'd2, 1'b0);
    load_chk("R5 const flag differs", 1'b1, 16'd3, 1'b0, 16'd5, 3'd2, 1'b0);
    end_grp();
    load_chk("R8 cleared", 1'b0, 16'd3, 1'b0, 16'd5, 3'd2, 1'b0);

    // R5 non-constant first operands, shared base
    store(1'b0, 16'd8, 1'b0, 16'd1, 3'd4);
    load_chk("R5 nonconst first", 1'b0, 16'd9, 1'b0, 16'd1, 3'd4, 1'b0);
    end_grp();
    // R5 constant overlap but different base
    store(1'b1, 16'd8, 1'b0, 16'd1, 3'd3);
    load_chk("R5 diff base", 1'b1, 16'd8, 1'b0, 16'd2, 3'd3, 1'b0);
    load_chk("R4 adjacent", 1'b1, 16'd16, 1'b0, 16'd1, 3'd3, 1'b0);
    load_chk("R4 inside", 1'b1, 16'd15, 1'b0, 16'd1, 3'd0, 1'b1);
    end_grp();

    // R10 no wrap at 16 bits
    store(1'b1, 16'hFFF8, 1'b0, 16'd7, 3'd4);
    load_chk("R10 high end", 1'b1, 16'hFFFF, 1'b0, 16'd7, 3'd0, 1'b1);
    load_chk("R10 low side", 1'b1, 16'h0000, 1'b0, 16'd7, 3'd4, 1'b0);
    end_grp();
    store(1'b1, 16'hFFFF, 1'b0, 16'd7, 3'd4);
    load_chk("R10 unsigned", 1'b1, 16'h0004, 1'b0, 16'd7, 3'd2, 1'b0);
    end_grp();

    // R7 same-cycle store and load
    set_st(1'b0, 16'd11, 1'b0, 16'd12, 3'd1);
    load_chk("R7 same cycle", 1'b0, 16'd11, 1'b0, 16'd12, 3'd1, 1'b0);
    load_chk("R7 next cycle", 1'b0, 16'd11, 1'b0, 16'd12, 3'd1, 1'b1);
    // R8 load in group-end cycle sees old table; store with group end discarded
    grp_end_i = 1'b1;
    set_st(1'b0, 16'd20, 1'b0, 16'd21, 3'd0);
    load_chk("R8 old table", 1'b0, 16'd11, 1'b0, 16'd12, 3'd1, 1'b1);
    load_chk("R8 emptied", 1'b0, 16'd11, 1'b0, 16'd12, 3'd1, 1'b0);
    load_chk("R8 store discarded", 1'b0, 16'd20, 1'b0, 16'd21, 3'd0, 1'b0);

    // R9 capacity and sticky overflow
    for (int i = 0; i < 4; i++) store(1'b0, 16'(40 + i), 1'b0, 16'd50, 3'd0);
    chk("R9 no ovf at 4", ovf_o, 1'b0);
    store(1'b0, 16'd44, 1'b0, 16'd50, 3'd0);
    chk("R9 ovf set", ovf_o, 1'b1);
    load_chk("R9 fifth dropped", 1'b0, 16'd44, 1'b0, 16'd50, 3'd0, 1'b0);
    for (int i = 0; i < 4; i++)
      load_chk("R9 held entry", 1'b0, 16'(40 + i), 1'b0, 16'd50, 3'd0, 1'b1);
    end_grp();
    chk("R9 ovf sticky", ovf_o, 1'b1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk("R1 ovf cleared", ovf_o, 1'b0);

    // R4 sweep over offsets and sizes with a shared register base
    for (int so = 0; so < 13; so++)
      for (int ss = 0; ss < 5; ss++)
        for (int lo = 0; lo < 21; lo++)
          for (int ls = 0; ls < 5; ls++) begin
            store(1'b1, 16'(so), 1'b0, 16'd9, 3'(ss));
            load_chk("R4 sweep", 1'b1, 16'(lo), 1'b0, 16'd9, 3'(ls),
                     overlap(so, ss, lo, ls));
            end_grp();
          end

    done = 1;
    finish_run();
  end
endmodule